// File: doc/BRIEF.md
# Static Memory Port Controller

This block sits between a synchronous on-chip bus and external asynchronous static memory with a 32-bit data path. It captures the bus address, transfer size, direction and write data when a request is accepted. It then holds these values on the memory side until the access is complete. A counter inserts a fixed number of wait cycles, with separate build-time settings for reads and writes. An external wait input can stretch any access for as long as it stays high. While the access is still running, a bus-side wait output stalls the master.

The controller drives eight active-low bank selects and four active-low byte write strobes. It also drives an active-low output enable and a data-drive enable for the external bus. The tristate bus is modelled as three separate ports: outgoing data, a drive enable and incoming data.

A request is presented for one cycle, with `bus_sel` high. The access cycles follow it, and the last of them is the one in which `bus_wait` is low.

Top module: `sram_port_ctrl`

## Requirements
- R1: A read with the external wait low shows `bus_wait` high for exactly RD_WAIT cycles (0 to 3) after the request cycle, followed by one final cycle with `bus_wait` low.
- R2: A write with the external wait low shows `bus_wait` high for exactly WR_WAIT cycles (1 to 3; 0 is not a legal setting) before its final cycle.
- R3: During a write, the strobes selected by R11 are low in every cycle with `bus_wait` high. All strobes are high in the final cycle, during reads and while idle.
- R4: `mem_addr` and, for writes, `mem_dout` hold the request values through the whole access. For a write, `mem_oe_n` is high and `mem_doe` is high. For a read, `mem_oe_n` is low and `mem_doe` is low.
- R5: If `mem_wait` is high in the request cycle and the H-1 cycles after it, the access has max(W, H) wait cycles, where W is the configured wait count. So the access ends only after `mem_wait` has been low for a cycle.
- R6: On a zero-wait read, `mem_wait` high in the request cycle alone inserts exactly one `bus_wait` cycle.
- R7: In the final cycle of a read, `bus_rdata` equals `mem_din`. In all other cycles it is zero.
- R8: With no access pending, `mem_cs_n` is 8'hFF. With `remap` at 0, an access drives only bit 7 low. With `remap` at 1, only the bit indexed by address bits [30:28] is low.
- R9: `mem_cs_n` is updated on the falling clock edge, so it is valid in the second half of the request cycle. It returns to 8'hFF in the second half of the final cycle.
- R10: While `rst_n` is low, `mem_cs_n` is forced to 8'hFF immediately, without waiting for a clock edge.
- R11: Strobe bit n (`mem_we_n`) serves byte lane n. Size 2'b10 (word) gives 4'b0000. Size 2'b01 (halfword) gives 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1. Size 2'b00 (byte) gives 4'b1110, 4'b1101, 4'b1011 or 4'b0111 for low address bits 0, 1, 2 or 3.
- R12: When idle and after reset, `bus_wait` is low, `mem_oe_n` is high, `mem_doe` is low and `mem_we_n` is 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request for an external memory access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Transfer size code (R11) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| remap | input | 1 | Selects the address-indexed bank decode |
| bus_rdata | output | 32 | Read data returned to the bus |
| bus_wait | output | 1 | Stalls the bus master |
| mem_addr | output | AW | Latched external address |
| mem_dout | output | 32 | Data driven onto the external bus |
| mem_doe | output | 1 | External data drive enable |
| mem_din | input | 32 | Data sampled from the external bus |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 4 | Active-low byte write strobes |
| mem_cs_n | output | 8 | Active-low bank selects |
| mem_wait | input | 1 | External request to stretch the access |

## Verification
The properties assume that `bus_size` never takes the unused code 2'b11. They also assume that a new request arrives only while the controller is idle or in its final cycle. The stimulus keeps to both assumptions: each request lasts one cycle, and `bus_sel` stays low until every instance has finished. The properties further assume that `mem_wait` changes only between clock edges. The bench drives every input just after the rising edge, which satisfies this. Four instances with different wait settings run side by side on the same stimulus, so every read and write setting is swept together.

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl #(
  parameter int RD_WAIT = 1,
  parameter int WR_WAIT = 1,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          remap,
  output logic [31:0]   bus_rdata,
  output logic          bus_wait,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_dout,
  output logic          mem_doe,
  input  logic [31:0]   mem_din,
  output logic          mem_oe_n,
  output logic [3:0]    mem_we_n,
  output logic [7:0]    mem_cs_n,
  input  logic          mem_wait
);
  localparam logic [1:0] RD_CNT = 2'(RD_WAIT);
  localparam logic [1:0] WR_CNT = 2'(WR_WAIT);

  logic          busy, wr_q, xw_q;
  logic [1:0]    cnt;
  logic [AW-1:0] addr_q;
  logic [31:0]   wd_q;
  logic [3:0]    lane_n_q;

  function automatic logic [3:0] lanes_n(input logic [1:0] sz, input logic [1:0] a);
    case (sz)
      2'b00:   return ~(4'b0001 << a);
      2'b01:   return a[1] ? 4'b0011 : 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [7:0] bank_n(input logic act, input logic rm, input logic [2:0] b);
    if (!act)    return 8'hFF;
    else if (rm) return ~(8'b1 << b);
    else         return 8'h7F;
  endfunction

  wire last  = busy && cnt == 2'd0 && !xw_q;
  wire start = bus_sel && (!busy || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wr_q     <= 1'b0;
      xw_q     <= 1'b0;
      cnt      <= 2'd0;
      addr_q   <= '0;
      wd_q     <= '0;
      lane_n_q <= 4'hF;
    end else begin
      xw_q <= mem_wait;
      if (start) begin
        busy     <= 1'b1;
        wr_q     <= bus_write;
        cnt      <= bus_write ? WR_CNT : RD_CNT;
        addr_q   <= bus_addr;
        wd_q     <= bus_wdata;
        lane_n_q <= lanes_n(bus_size, bus_addr[1:0]);
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy && cnt != 2'd0) begin
        cnt <= cnt - 2'd1;
      end
    end
  end

  wire          busy_nx = start || (busy && !last);
  wire [AW-1:0] addr_nx = start ? bus_addr : addr_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mem_cs_n <= 8'hFF;
    else        mem_cs_n <= bank_n(busy_nx, remap, addr_nx[30:28]);
  end

  assign bus_wait  = busy && !last;
  assign mem_addr  = addr_q;
  assign mem_dout  = wd_q;
  assign mem_doe   = busy && wr_q;
  assign mem_oe_n  = !(busy && !wr_q);
  assign mem_we_n  = (busy && wr_q && !last) ? lane_n_q : 4'hF;
  assign bus_rdata = (last && !wr_q) ? mem_din : 32'h0;
endmodule

module sram_port_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wait,
  input logic          mem_wait,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_dout,
  input logic          mem_doe,
  input logic          mem_oe_n,
  input logic [3:0]    mem_we_n,
  input logic [7:0]    mem_cs_n
);
  a_r3_strobe_only_waited: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n != 4'hF) |-> bus_wait);
  a_r3_final_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wait |-> mem_we_n == 4'hF);
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |=> $stable(mem_addr) && $stable(mem_dout));
  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_doe && mem_we_n == 4'hF);
  a_r5_ext_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wait && mem_wait) |=> bus_wait);
  a_r8_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n && !mem_doe) |-> mem_we_n == 4'hF && !bus_wait);
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_sram_port_ctrl.sv
`timescale 1ns/100ps
module sim_sram_port_ctrl;
  localparam int N = 4;
  localparam int RW [N] = '{0, 1, 2, 3};
  localparam int WW [N] = '{1, 2, 3, 1};

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_write = 0, remap = 0, mem_wait = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, mem_din = 0;

  logic [31:0] rdata [N];
  logic        bw [N];
  logic [31:0] maddr [N];
  logic [31:0] dout [N];
  logic        doe [N];
  logic        oe_n [N];
  logic [3:0]  we_n [N];
  logic [7:0]  cs_n [N];

  int vectors = 0, errs = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : cfg
    sram_port_ctrl #(.RD_WAIT(RW[g]), .WR_WAIT(WW[g])) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .remap(remap), .bus_rdata(rdata[g]), .bus_wait(bw[g]),
      .mem_addr(maddr[g]), .mem_dout(dout[g]), .mem_doe(doe[g]),
      .mem_din(mem_din), .mem_oe_n(oe_n[g]), .mem_we_n(we_n[g]),
      .mem_cs_n(cs_n[g]), .mem_wait(mem_wait));
  end

  task automatic chk(input bit ok, input string req, input int k,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cfg%0d act=%0h exp=%0h", req, k, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] a);
    if (sz == 2'b10) return 4'h0;
    if (sz == 2'b01) return ~(4'b0011 << (2 * a[1]));
    return ~(4'b0001 << a);
  endfunction

  task automatic idle_chk(input int k);
    chk(bw[k] == 0, "R12 bus_wait", k, bw[k], 0);
    chk(oe_n[k] == 1 && doe[k] == 0, "R12 oe/doe", k, {oe_n[k], doe[k]}, 2'b10);
    chk(we_n[k] == 4'hF, "R12 we_n", k, we_n[k], 4'hF);
    chk(rdata[k] == 0, "R7 rdata idle", k, rdata[k], 0);
  endtask

  task automatic xfer(input bit w, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] d, input bit rm, input int h);
    int cnt [N];
    bit done [N];
    logic [7:0] ecs;
    @(posedge clk); #0.5;
    bus_sel = 1; bus_write = w; bus_size = sz; bus_addr = a; bus_wdata = d;
    remap = rm; mem_wait = (h > 0); mem_din = $urandom;
    #4;
    ecs = rm ? ~(8'b1 << a[30:28]) : 8'h7F;
    for (int k = 0; k < N; k++) begin
      cnt[k] = 0; done[k] = 0;
      chk(cs_n[k] == ecs, "R8 R9 cs decode", k, cs_n[k], ecs);
      chk(bw[k] == 0, "R12 no wait at request", k, bw[k], 0);
    end
    for (int i = 1; i < 20; i++) begin
      @(posedge clk); #0.5;
      bus_sel = 0; mem_wait = (i < h);
      #4;
      for (int k = 0; k < N; k++) begin
        if (done[k]) idle_chk(k);
        else if (bw[k]) begin
          cnt[k]++;
          chk(we_n[k] == (w ? exp_lanes(sz, a[1:0]) : 4'hF), w ? "R3 R11 strobe" : "R3 read strobe",
              k, we_n[k], w ? exp_lanes(sz, a[1:0]) : 4'hF);
          chk(maddr[k] == a, "R4 addr", k, maddr[k], a);
          chk(oe_n[k] == w && doe[k] == w, "R4 direction", k, {oe_n[k], doe[k]}, {w, w});
          if (w) chk(dout[k] == d, "R4 wdata", k, dout[k], d);
          chk(cs_n[k] == ecs, "R9 cs held", k, cs_n[k], ecs);
        end else begin
          int wt, e;
          done[k] = 1;
          wt = w ? WW[k] : RW[k];
          e = (h > wt) ? h : wt;
          chk(cnt[k] == e, w ? "R2 R5 write waits" : (wt == 0 && h == 1) ? "R6 stall" : "R1 R5 read waits",
              k, cnt[k], e);
          chk(we_n[k] == 4'hF, "R3 final strobe high", k, we_n[k], 4'hF);
          chk(cs_n[k] == 8'hFF, "R9 cs release", k, cs_n[k], 8'hFF);
          if (!w) chk(rdata[k] == mem_din, "R7 rdata", k, rdata[k], mem_din);
        end
      end
      if (done[0] && done[1] && done[2] && done[3]) break;
    end
    for (int k = 0; k < N; k++) chk(done[k], "R1 R2 completion", k, done[k], 1);
  endtask

  initial begin
    #12;
    for (int k = 0; k < N; k++) begin
      chk(cs_n[k] == 8'hFF, "R10 cs in reset", k, cs_n[k], 8'hFF);
      idle_chk(k);
    end
    @(negedge clk); rst_n = 1;
    for (int h = 0; h < 5; h++)
      for (int sz = 0; sz < 3; sz++)
        for (int a = 0; a < 4; a++) begin
          xfer(1, 2'(sz), 32'h1000_0000 | 32'(a) | 32'(h << 4), $urandom, 1, h);
          xfer(0, 2'(sz), 32'h2000_0000 | 32'(a) | 32'(h << 4), 0, 0, h);
        end
    for (int rm = 0; rm < 2; rm++)
      for (int b = 0; b < 8; b++)
        xfer(b[0], 2'b10, 32'(b) << 28, 32'hA5A5_0000 | 32'(b), rm[0], 0);
    @(posedge clk); #0.5;
    bus_sel = 1; bus_write = 1; bus_size = 2'b10; bus_addr = 32'h3000_0000; remap = 1;
    @(posedge clk); #0.5; bus_sel = 0;
    #1;
    for (int k = 0; k < N; k++) chk(cs_n[k] == 8'hF7, "R8 cs before reset", k, cs_n[k], 8'hF7);
    rst_n = 0; #0.2;
    for (int k = 0; k < N; k++) begin
      chk(cs_n[k] == 8'hFF, "R10 async cs", k, cs_n[k], 8'hFF);
      chk(we_n[k] == 4'hF && bw[k] == 0, "R12 after reset", k, {we_n[k], bw[k]}, 5'h1E);
    end
    #5;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule